// File: doc/BRIEF.md
# Duty-Cycled Wake-Up Controller with Interval Window Check

This block keeps a low-rate radio receiver asleep most of the time and wakes it only when a transmitter is likely present. It counts a programmable sleep period, then turns on the receive signal path. After a fixed settling interval it times the gaps between level changes of the demodulated data, in ticks of a divided clock. Each gap is compared with a programmable lower and upper limit. When enough consecutive gaps fall inside the window, the block enters receiving mode and passes the data through. Any gap outside the window sends it back to sleep at once.

A host sets the limits, the sleep multiplier, the sleep extension factors, the clock divisor and the number of gaps required. While receiving, the block stays awake until the host raises an off request or lowers the polling enable. A sleep multiplier of all ones parks the block in sleep indefinitely. A temporary extension lengthens sleep only while wake-up checks keep succeeding.

Top module: `poll_wake_ctl`

## Requirements
- R1: In reset the state output reads 0 (sleep), the path enable is low and the data output is low. State codes are sleep = 0, settling = 1, checking = 2, receiving = 3.
- R2: With polling enabled, sleep lasts max(1, M × SLEEP_UNIT × F) clock cycles. M is `sleep_mult`. F = 1 + `ext_std` + (`ext_tmp` if the temporary extension is active, else 0). The block then moves to settling.
- R3: When `sleep_mult` is all ones, the block stays in sleep for as long as that value is held.
- R4: Settling lasts STARTUP_CYC cycles with the path enable high. Data level changes during settling have no effect on the check that follows.
- R5: The gap tick counts basic clock cycles divided by DIV_A when `div_sel` is 0 and by DIV_B when it is 1. A gap of L cycles between changes measures floor((L−1)/divisor) ticks.
- R6: A measured gap below `lim_lo` ends the check, and the block returns to sleep the next cycle.
- R7: The gap value saturates at `lim_hi`. Reaching `lim_hi` ends the check and returns the block to sleep, with or without a further level change.
- R8: The first level change in checking only starts timing. When `bits_req` consecutive gaps lie in [`lim_lo`, `lim_hi`), the block enters receiving. A `bits_req` of 0 acts as 1. Receiving is entered only from checking.
- R9: A passed check activates the temporary extension and a failed check clears it. `ext_std` applies to every sleep.
- R10: In receiving, `data_out` equals `demod_in`. In every other state it is 0.
- R11: `off_req` in receiving returns the block to sleep on the next cycle. In other states it has no effect.
- R12: With `poll_en` low, the block is in sleep from the next cycle on and does not count sleep time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_en | input | 1 | Polling enable; low forces and holds sleep |
| off_req | input | 1 | Return-to-sleep request while receiving |
| demod_in | input | 1 | Demodulated data level |
| lim_lo | input | LIM_W | Lower gap limit in ticks |
| lim_hi | input | LIM_W | Upper gap limit in ticks (exclusive) |
| sleep_mult | input | MULT_W | Sleep multiplier; all ones = permanent sleep |
| ext_std | input | EXT_W | Standard sleep extension |
| ext_tmp | input | EXT_W | Temporary sleep extension |
| div_sel | input | 1 | Tick divisor select |
| bits_req | input | NB_W | Consecutive in-window gaps required |
| path_on | output | 1 | Receive path enable |
| rx_state | output | 2 | Current state code |
| data_out | output | 1 | Gated data output |

## Verification
Every cycle, the assertions check which state transitions are allowed. Sleep may only lead to settling, and receiving may only be entered from checking. The path may only switch on into settling. An off request or a low polling enable must force sleep, and an all-ones multiplier must hold sleep. Exact durations cannot be seen by those properties and are left to the bench scenarios. These cover sleep length with and without the temporary extension, settling length, timeout length under both divisors, and window pass and fail for gaps on either side of the limits.

// File: rtl/poll_ctl_pkg.sv
package poll_ctl_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_START = 2'd1,
        ST_CHECK = 2'd2,
        ST_RECV  = 2'd3
    } poll_state_e;

    typedef enum logic [1:0] {
        VD_BUSY = 2'd0,
        VD_FAIL = 2'd1,
        VD_PASS = 2'd2
    } verdict_e;

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/poll_tick_div.sv
module poll_tick_div #(
    parameter int unsigned DIV_A = 10,
    parameter int unsigned DIV_B = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    input  logic sel,
    output logic tick
);
    import poll_ctl_pkg::*;

    localparam int unsigned PRE_W = $clog2(max_u(DIV_A, DIV_B));

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last_v;

    assign last_v = sel ? PRE_W'(DIV_B - 1) : PRE_W'(DIV_A - 1);
    assign tick   = active && !restart && (pre_q == last_v);

    always_ff @(posedge clk) begin
        if (rst || !active || restart || pre_q == last_v) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/poll_span_timer.sv
module poll_span_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         freeze,
    input  logic [W-1:0] span,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = run && !freeze && (({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, span});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/poll_interval_chk.sv
module poll_interval_chk #(
    parameter int unsigned LIM_W = 5,
    parameter int unsigned NB_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         active,
    input  logic                         dflip,
    input  logic                         tick,
    input  logic [LIM_W-1:0]             lim_lo,
    input  logic [LIM_W-1:0]             lim_hi,
    input  logic [NB_W-1:0]              bits_req,
    output poll_ctl_pkg::verdict_e       verdict
);
    import poll_ctl_pkg::*;

    logic [LIM_W-1:0] cv_q;
    logic             started_q;
    logic [NB_W-1:0]  nbits_q;
    logic [NB_W:0]    need;
    logic [NB_W:0]    nb_inc;

    assign need   = (bits_req == '0) ? (NB_W+1)'(1) : {1'b0, bits_req};
    assign nb_inc = {1'b0, nbits_q} + (NB_W+1)'(1);

    always_comb begin
        verdict = VD_BUSY;
        if (active) begin
            if (dflip && started_q) begin
                if (cv_q < lim_lo || cv_q >= lim_hi) begin
                    verdict = VD_FAIL;
                end else if (nb_inc >= need) begin
                    verdict = VD_PASS;
                end
            end else if (cv_q >= lim_hi) begin
                verdict = VD_FAIL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cv_q      <= '0;
            started_q <= 1'b0;
            nbits_q   <= '0;
        end else if (dflip) begin
            cv_q      <= '0;
            started_q <= 1'b1;
            if (started_q && verdict == VD_BUSY) begin
                nbits_q <= nbits_q + 1'b1;
            end
        end else if (tick && cv_q < lim_hi) begin
            cv_q <= cv_q + 1'b1;
        end
    end

endmodule

// File: rtl/poll_wake_ctl.sv
module poll_wake_ctl #(
    parameter int unsigned LIM_W       = 5,
    parameter int unsigned MULT_W      = 5,
    parameter int unsigned EXT_W       = 2,
    parameter int unsigned NB_W        = 3,
    parameter int unsigned SLEEP_UNIT  = 1024,
    parameter int unsigned STARTUP_CYC = 64,
    parameter int unsigned DIV_A       = 10,
    parameter int unsigned DIV_B       = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_en,
    input  logic              off_req,
    input  logic              demod_in,
    input  logic [LIM_W-1:0]  lim_lo,
    input  logic [LIM_W-1:0]  lim_hi,
    input  logic [MULT_W-1:0] sleep_mult,
    input  logic [EXT_W-1:0]  ext_std,
    input  logic [EXT_W-1:0]  ext_tmp,
    input  logic              div_sel,
    input  logic [NB_W-1:0]   bits_req,
    output logic              path_on,
    output logic [1:0]        rx_state,
    output logic              data_out
);
    import poll_ctl_pkg::*;

    localparam int unsigned MAX_FACT = 1 + 2 * ((1 << EXT_W) - 1);
    localparam int unsigned SLP_W    = $clog2(((1 << MULT_W) - 1) * SLEEP_UNIT * MAX_FACT + 1);
    localparam int unsigned ST_W     = $clog2(STARTUP_CYC + 1);

    poll_state_e       state_q, state_d;
    verdict_e          verdict;
    logic              demod_q;
    logic              dflip;
    logic              temp_on_q;
    logic              tick;
    logic              slp_done;
    logic              su_done;
    logic [SLP_W-1:0]  factor;
    logic [SLP_W-1:0]  sleep_len;

    assign dflip     = demod_in ^ demod_q;
    assign factor    = SLP_W'(1) + SLP_W'(ext_std) + (temp_on_q ? SLP_W'(ext_tmp) : '0);
    assign sleep_len = SLP_W'(sleep_mult) * SLP_W'(SLEEP_UNIT) * factor;

    poll_span_timer #(.W(SLP_W)) u_slp (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == ST_SLEEP && poll_en),
        .freeze (&sleep_mult),
        .span   (sleep_len),
        .done   (slp_done)
    );

    poll_span_timer #(.W(ST_W)) u_settle (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == ST_START),
        .freeze (1'b0),
        .span   (ST_W'(STARTUP_CYC)),
        .done   (su_done)
    );

    poll_tick_div #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_div (
        .clk     (clk),
        .rst     (rst),
        .active  (state_q == ST_CHECK),
        .restart (dflip),
        .sel     (div_sel),
        .tick    (tick)
    );

    poll_interval_chk #(.LIM_W(LIM_W), .NB_W(NB_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .active   (state_q == ST_CHECK),
        .dflip    (dflip),
        .tick     (tick),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .bits_req (bits_req),
        .verdict  (verdict)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_SLEEP: if (slp_done) state_d = ST_START;
            ST_START: if (su_done)  state_d = ST_CHECK;
            ST_CHECK: begin
                if (verdict == VD_FAIL)      state_d = ST_SLEEP;
                else if (verdict == VD_PASS) state_d = ST_RECV;
            end
            ST_RECV:  if (off_req)  state_d = ST_SLEEP;
            default:  state_d = ST_SLEEP;
        endcase
        if (!poll_en) state_d = ST_SLEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_SLEEP;
            demod_q   <= 1'b0;
            temp_on_q <= 1'b0;
        end else begin
            state_q <= state_d;
            demod_q <= demod_in;
            if (verdict == VD_FAIL)      temp_on_q <= 1'b0;
            else if (verdict == VD_PASS) temp_on_q <= 1'b1;
        end
    end

    assign rx_state = state_q;
    assign path_on  = (state_q != ST_SLEEP);
    assign data_out = (state_q == ST_RECV) & demod_in;

endmodule

// File: rtl/poll_wake_ctl_chk.sv
module poll_wake_ctl_chk #(
    parameter int unsigned MULT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              poll_en,
    input logic              off_req,
    input logic [MULT_W-1:0] sleep_mult,
    input logic              path_on,
    input logic [1:0]        rx_state
);
    import poll_ctl_pkg::*;

    assert_sleep_exit_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_state == ST_SLEEP) |=> (rx_state == ST_SLEEP || rx_state == ST_START));

    assert_perm_sleep_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_state == ST_SLEEP && sleep_mult == '1) |=> (rx_state == ST_SLEEP));

    assert_path_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(path_on) |-> (rx_state == ST_START));

    assert_recv_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_state != ST_RECV) |=> (rx_state != ST_RECV || $past(rx_state) == ST_CHECK));

    assert_off_cmd_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_state == ST_RECV && off_req) |=> (rx_state == ST_SLEEP));

    assert_poll_low_R12: assert property (@(posedge clk) disable iff (rst)
        !poll_en |=> (rx_state == ST_SLEEP));

endmodule

bind poll_wake_ctl poll_wake_ctl_chk #(.MULT_W(MULT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .poll_en    (poll_en),
    .off_req    (off_req),
    .sleep_mult (sleep_mult),
    .path_on    (path_on),
    .rx_state   (rx_state)
);

// File: tb/test_poll_wake_ctl.sv
`timescale 1ns/1ps
module test_poll_wake_ctl;

    localparam int UNIT = 4;
    localparam int SU   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       poll_en = 1'b0;
    logic       off_req = 1'b0;
    logic       demod = 1'b0;
    logic [4:0] lim_lo = 5'd2;
    logic [4:0] lim_hi = 5'd5;
    logic [4:0] sleep_mult = 5'd2;
    logic [1:0] ext_std = 2'd1;
    logic [1:0] ext_tmp = 2'd2;
    logic       div_sel = 1'b0;
    logic [2:0] bits_req = 3'd3;
    logic       path_on;
    logic [1:0] rx_state;
    logic       data_out;

    int checks = 0;
    int fails = 0;
    int gen_per = 0;
    int gen_cnt = 0;
    string cur_req = "R1";

    int m_st, m_cnt, m_temp, m_L, m_started, m_nb;
    logic m_prev;

    always #2 clk = ~clk;

    poll_wake_ctl #(
        .SLEEP_UNIT(UNIT), .STARTUP_CYC(SU), .DIV_A(10), .DIV_B(14)
    ) i_poll_wake_ctl (
        .clk(clk), .rst(rst), .poll_en(poll_en), .off_req(off_req), .demod_in(demod),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .sleep_mult(sleep_mult), .ext_std(ext_std),
        .ext_tmp(ext_tmp), .div_sel(div_sel), .bits_req(bits_req),
        .path_on(path_on), .rx_state(rx_state), .data_out(data_out)
    );

    // behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        int dv, nd, nx, cv, len;
        bit fl, pass, fail;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_temp = 0; m_prev = 1'b0;
            m_L = 1; m_started = 0; m_nb = 0;
        end else begin
            fl = (demod != m_prev);
            m_prev = demod;
            dv = div_sel ? 14 : 10;
            nd = (bits_req == 0) ? 1 : int'(bits_req);
            nx = m_st; pass = 0; fail = 0;
            case (m_st)
                0: if (poll_en && sleep_mult != 5'd31) begin
                       len = int'(sleep_mult) * UNIT * (1 + int'(ext_std) + (m_temp != 0 ? int'(ext_tmp) : 0));
                       if (m_cnt + 1 >= len) nx = 1;
                   end
                1: if (m_cnt + 1 >= SU) nx = 2;
                2: begin
                       cv = (m_L - 1) / dv;
                       if (cv > int'(lim_hi)) cv = int'(lim_hi);
                       if (fl && m_started != 0) begin
                           if (cv < int'(lim_lo) || cv >= int'(lim_hi)) fail = 1;
                           else if (m_nb + 1 >= nd) pass = 1;
                           else m_nb = m_nb + 1;
                       end else if (cv >= int'(lim_hi)) fail = 1;
                       if (fl) begin m_started = 1; m_L = 1; end
                       else m_L = m_L + 1;
                   end
                default: if (off_req) nx = 0;
            endcase
            if (fail) begin nx = 0; m_temp = 0; end
            if (pass) begin nx = 3; m_temp = 1; end
            if (!poll_en) nx = 0;
            if (nx != m_st || (m_st == 0 && !poll_en)) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (nx == 2 && m_st != 2) begin m_L = 1; m_started = 0; m_nb = 0; end
            m_st = nx;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        checks++;
        if (int'(rx_state) != m_st || path_on != (m_st != 0) ||
            data_out != ((m_st == 3) && demod)) begin
            fails++;
            $display("FAIL %s actual=%0d/%0b/%0b expected=%0d/%0b/%0b", cur_req,
                     rx_state, path_on, data_out, m_st, (m_st != 0), ((m_st == 3) && demod));
        end
        if (gen_per > 0) begin
            gen_cnt++;
            if (gen_cnt >= gen_per) begin demod = ~demod; gen_cnt = 0; end
        end
    endtask

    task automatic wait_state(input int target, input int maxc, output int n);
        n = 0;
        while (int'(rx_state) != target && n < maxc) begin step(); n++; end
    endtask

    task automatic wait_leave(input int st, input int maxc);
        int n = 0;
        while (int'(rx_state) == st && n < maxc) begin step(); n++; end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 180000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        check("R1 state", int'(rx_state), 0);
        check("R1 path", int'(path_on), 0);
        check("R1 data", int'(data_out), 0);

        // R12: polling disabled holds sleep
        cur_req = "R12";
        repeat (20) step();
        check("R12 idle", int'(rx_state), 0);

        // R2: sleep 2*4*(1+1) = 16 cycles
        cur_req = "R2";
        poll_en = 1'b1;
        wait_state(1, 200, n);
        check("R2 sleep len", n, 16);

        // R4: settling 6 cycles, level changes in it ignored
        cur_req = "R4";
        demod = ~demod; step();
        demod = ~demod; step();
        demod = ~demod; step();
        demod = ~demod;
        wait_state(2, 50, n);
        check("R4 settle len", n, 3);

        // R7: no change -> timeout after 5*10+1 cycles
        cur_req = "R7";
        wait_state(0, 200, n);
        check("R7 timeout div10", n, 51);

        // R5: divisor 14 -> 5*14+1 cycles
        cur_req = "R5";
        div_sel = 1'b1;
        wait_state(2, 200, n);
        wait_state(0, 200, n);
        check("R5 timeout div14", n, 71);

        // R5: gap of 25 gives 1 tick at /14 -> fails
        gen_per = 25;
        wait_state(2, 200, n);
        wait_leave(2, 300);
        check("R5 gap25 div14 fail", int'(rx_state), 0);

        // R6: gap of 10 gives 0 ticks, below lower limit
        cur_req = "R6";
        div_sel = 1'b0;
        gen_per = 10;
        wait_state(2, 200, n);
        wait_leave(2, 300);
        check("R6 short gap", int'(rx_state), 0);

        // R8: gap of 25 gives 2 ticks at /10, three gaps pass
        cur_req = "R8";
        gen_per = 25;
        wait_state(2, 200, n);
        wait_leave(2, 300);
        check("R8 pass", int'(rx_state), 3);

        // R10: data passes through while receiving
        cur_req = "R10";
        for (int i = 0; i < 5; i++) begin
            repeat (7) step();
            check("R10 data", int'(data_out), int'(demod));
        end

        // R11 and R9: off request, then sleep with temp extension 2*4*(1+1+2) = 32
        cur_req = "R11";
        gen_per = 0;
        off_req = 1'b1;
        step();
        check("R11 off", int'(rx_state), 0);
        cur_req = "R9";
        wait_state(1, 200, n);
        check("R9 temp ext sleep", n, 32);
        off_req = 1'b0;

        // R9: failed check clears temp extension
        wait_state(2, 50, n);
        wait_state(0, 200, n);
        check("R9 fail timeout", n, 51);
        wait_state(1, 200, n);
        check("R9 temp cleared", n, 16);

        // R8: zero required gaps acts as one
        cur_req = "R8";
        bits_req = 3'd0;
        gen_per = 25;
        wait_state(2, 50, n);
        wait_leave(2, 300);
        check("R8 bits0", int'(rx_state), 3);

        // R12: dropping enable in receiving forces sleep
        cur_req = "R12";
        poll_en = 1'b0;
        step();
        check("R12 drop", int'(rx_state), 0);
        repeat (20) step();
        check("R12 hold", int'(rx_state), 0);

        // R3: all-ones multiplier never wakes
        cur_req = "R3";
        gen_per = 0;
        sleep_mult = 5'd31;
        poll_en = 1'b1;
        wait_state(1, 300, n);
        check("R3 permanent", n, 300);
        check("R3 state", int'(rx_state), 0);

        finish_run();
    end

endmodule